// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses of 4 KB pages into physical addresses for one core side. It holds four ways of four entries; each entry carries a tag, a physical page number, a 4-bit rights attribute and an 8-bit address-space identifier. All ways are compared in parallel. The result of each lookup is registered and returned one cycle later with a valid strobe, together with either the physical address or a fault cause.

Privilege comes from the address-space identifier. A 32-bit ring map register holds one identifier per privilege ring, ring 0 in the low byte. An entry takes part in a lookup only while its identifier appears in that register, and the byte position where it appears is the entry's ring. Entries are loaded and invalidated through dedicated ports addressed by way and index. A probe request reports where a page is held without checking rights. Refilling from page tables belongs to another block.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, `rasid_q` reads 0x04030201, `rsp_valid` is 0 and `rsp_cause`, `rsp_paddr` and `rsp_probe` are 0; a lookup then misses.
- R2: A lookup reads the entry at index `req_vaddr[13:12]` in every way and hits only where the stored tag equals `req_vaddr[31:14]`; a clean hit returns `{ppn, req_vaddr[11:0]}` on `rsp_paddr`.
- R3: An entry whose identifier is 0 never hits; an invalidate sets the addressed entry's identifier to 0, and it wins over a write to the same entry in the same cycle.
- R4: A write stores the identifier held in byte `wr_ring` of the ring map; at lookup the entry's ring is the lowest byte position of the ring map equal to its identifier, and an entry whose identifier is in no byte does not hit.
- R5: Cause codes are 0 none, 1 fetch miss, 2 fetch multi-hit, 3 fetch privilege, 4 fetch prohibited, 5 data miss, 6 data multi-hit, 7 data privilege, 8 load prohibited, 9 store prohibited; kind 2 is a fetch and uses 1 to 4, kinds 0 (load), 1 (store) and 3 (treated as load) use 5 to 9; priority is multi-hit (two or more hitting ways), miss, privilege, rights; `rsp_paddr` is 0 on any fault.
- R6: A single hit whose ring is numerically below `req_ring` yields the privilege cause.
- R7: Rights come from the attribute: below 12 grants read, with bit 0 adding execute and bit 1 adding write; 13 grants read and write; 12, 14 and 15 grant nothing. Load needs read, store needs write, fetch needs execute.
- R8: A write of the ring map stores the written word with bits [7:0] forced to 0x01.
- R9: A probe (`req_probe`=1) with a single hit at a ring not below `req_ring` returns `{req_vaddr[31:12], 7'b0, data, fetch, 1'b0, way[1:0]}` on `rsp_probe` (bit 4 set for kinds other than 2, bit 3 for kind 2); a miss or lower ring gives 0 with cause 0, a multi-hit gives 0 with the multi-hit cause; `rsp_paddr` is 0 for probes.
- R10: The response to a request sampled at a clock edge appears after that same edge with `rsp_valid`=1 for exactly that cycle and holds until the next request; a lookup in the cycle of a write or invalidate sees the entries before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup or probe request |
| req_probe | input | 1 | 1 = probe, 0 = translate |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| req_ring | input | 2 | Current privilege ring |
| req_vaddr | input | 32 | Virtual address |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way written |
| wr_idx | input | 2 | Index written |
| wr_tag | input | 18 | Virtual page bits above the index |
| wr_ppn | input | 20 | Physical page number |
| wr_attr | input | 4 | Rights attribute |
| wr_ring | input | 2 | Ring map byte giving the stored identifier |
| inv_en | input | 1 | Entry invalidate strobe |
| inv_way | input | 2 | Way invalidated |
| inv_idx | input | 2 | Index invalidated |
| rasid_we | input | 1 | Ring map write strobe |
| rasid_wdata | input | 32 | Ring map write data |
| rasid_q | output | 32 | Ring map contents |
| rsp_valid | output | 1 | Response strobe |
| rsp_cause | output | 4 | Fault cause, 0 when none |
| rsp_paddr | output | 32 | Translated address |
| rsp_probe | output | 32 | Probe result word |

## Verification
Every translation and probe result is due one clock after the edge that samples the request, so the bench raises the request on a falling edge, drops it on the next falling edge and samples the response there, half a period after the registering edge. Entry writes, invalidates and ring map writes take effect at the edge that samples them and are seen by requests sampled from the following edge on; the bench issues one same-cycle write and lookup to confirm that the lookup still sees the old contents, and checks `rsp_valid` falling one cycle later while the data holds.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

  localparam int ATTR_W = 4;

  typedef enum logic [3:0] {
    CAUSE_NONE      = 4'd0,
    CAUSE_I_MISS    = 4'd1,
    CAUSE_I_MULTI   = 4'd2,
    CAUSE_I_PRIV    = 4'd3,
    CAUSE_I_PROHIB  = 4'd4,
    CAUSE_D_MISS    = 4'd5,
    CAUSE_D_MULTI   = 4'd6,
    CAUSE_D_PRIV    = 4'd7,
    CAUSE_LD_PROHIB = 4'd8,
    CAUSE_ST_PROHIB = 4'd9
  } cause_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

  function automatic rights_t decode_rights(input logic [ATTR_W-1:0] attr);
    rights_t r;
    r = '0;
    if (attr < 4'd12) begin
      r.rd = 1'b1;
      r.ex = attr[0];
      r.wr = attr[1];
    end else if (attr == 4'd13) begin
      r.rd = 1'b1;
      r.wr = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/asid_tlb_way.sv
module asid_tlb_way #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 18,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [PPN_W-1:0]           wr_ppn,
  input  logic [ASID_W-1:0]          wr_asid,
  input  logic [ATTR_W-1:0]          wr_attr,
  input  logic                       inv_en,
  input  logic [$clog2(ENTRIES)-1:0] inv_idx,
  input  logic [$clog2(ENTRIES)-1:0] lk_idx,
  input  logic [TAG_W-1:0]           lk_tag,
  output logic                       lk_match,
  output logic [ASID_W-1:0]          lk_asid,
  output logic [PPN_W-1:0]           lk_ppn,
  output logic [ATTR_W-1:0]          lk_attr
);

  localparam int IDX_W = $clog2(ENTRIES);

  // Payload arrays carry no reset so they map onto distributed RAM.
  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [PPN_W-1:0]  ppn_mem  [ENTRIES];
  logic [ATTR_W-1:0] attr_mem [ENTRIES];
  // Identifiers double as valid flags and are reset.
  logic [ASID_W-1:0] asid_q   [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      ppn_mem[wr_idx]  <= wr_ppn;
      attr_mem[wr_idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) asid_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (inv_en && inv_idx == IDX_W'(e))
          asid_q[e] <= '0;
        else if (wr_en && wr_idx == IDX_W'(e))
          asid_q[e] <= wr_asid;
      end
    end
  end

  always_comb begin
    lk_asid  = asid_q[lk_idx];
    lk_ppn   = ppn_mem[lk_idx];
    lk_attr  = attr_mem[lk_idx];
    lk_match = (tag_mem[lk_idx] == lk_tag) && (lk_asid != '0);
  end

endmodule

// File: rtl/asid_tlb_ringmap.sv
module asid_tlb_ringmap #(
  parameter int NUM_RINGS = 4,
  parameter int ASID_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     we,
  input  logic [NUM_RINGS*ASID_W-1:0]              wdata,
  output logic [NUM_RINGS*ASID_W-1:0]              rasid_q,
  input  logic [$clog2(NUM_RINGS)-1:0]             wr_sel,
  output logic [ASID_W-1:0]                        wr_asid,
  input  logic [NUM_PORTS-1:0][ASID_W-1:0]         asids,
  output logic [NUM_PORTS-1:0]                     found,
  output logic [NUM_PORTS-1:0][$clog2(NUM_RINGS)-1:0] rings
);

  localparam int RING_W = $clog2(NUM_RINGS);
  localparam int MAP_W  = NUM_RINGS * ASID_W;

  function automatic logic [MAP_W-1:0] reset_map();
    logic [MAP_W-1:0] v;
    for (int i = 0; i < NUM_RINGS; i++) v[i*ASID_W +: ASID_W] = ASID_W'(i + 1);
    return v;
  endfunction

  logic unused_low_field;
  assign unused_low_field = ^wdata[ASID_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      rasid_q <= reset_map();
    else if (we)
      rasid_q <= {wdata[MAP_W-1:ASID_W], ASID_W'(1)};
  end

  assign wr_asid = rasid_q[wr_sel*ASID_W +: ASID_W];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      found[p] = 1'b0;
      rings[p] = '0;
      for (int i = NUM_RINGS - 1; i >= 0; i--) begin
        if (rasid_q[i*ASID_W +: ASID_W] == asids[p]) begin
          found[p] = 1'b1;
          rings[p] = RING_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/asid_tlb_resolve.sv
module asid_tlb_resolve
  import asid_tlb_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int RING_W    = 2,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  input  logic                                   req_probe,
  input  logic [1:0]                             req_kind,
  input  logic [RING_W-1:0]                      req_ring,
  input  logic [VA_W-1:0]                        req_vaddr,
  input  logic [NUM_WAYS-1:0]                    way_hit,
  input  logic [NUM_WAYS-1:0][RING_W-1:0]        way_ring,
  input  logic [NUM_WAYS-1:0][PA_W-PAGE_BITS-1:0] way_ppn,
  input  logic [NUM_WAYS-1:0][ATTR_W-1:0]        way_attr,
  output logic                                   rsp_valid,
  output logic [3:0]                             rsp_cause,
  output logic [PA_W-1:0]                        rsp_paddr,
  output logic [VA_W-1:0]                        rsp_probe
);

  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam int CNT_W = $clog2(NUM_WAYS + 1);

  logic [CNT_W-1:0]  nhits;
  logic [WAY_W-1:0]  sel;
  logic              data_side;
  rights_t           rights;
  logic              granted;
  cause_e            cause_n;
  logic [PA_W-1:0]   paddr_n;
  logic [VA_W-1:0]   probe_n;

  always_comb begin
    nhits = '0;
    sel   = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        nhits = nhits + CNT_W'(1);
        sel   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    data_side = (req_kind != ACC_FETCH);
    rights    = decode_rights(way_attr[sel]);
    case (req_kind)
      ACC_STORE: granted = rights.wr;
      ACC_FETCH: granted = rights.ex;
      default:   granted = rights.rd;
    endcase

    cause_n = CAUSE_NONE;
    paddr_n = '0;
    probe_n = '0;
    if (nhits > CNT_W'(1)) begin
      cause_n = data_side ? CAUSE_D_MULTI : CAUSE_I_MULTI;
    end else if (nhits == '0) begin
      if (!req_probe) cause_n = data_side ? CAUSE_D_MISS : CAUSE_I_MISS;
    end else if (req_probe) begin
      if (way_ring[sel] >= req_ring) begin
        probe_n[VA_W-1:PAGE_BITS] = req_vaddr[VA_W-1:PAGE_BITS];
        probe_n[4]                = data_side;
        probe_n[3]                = ~data_side;
        probe_n[WAY_W-1:0]        = sel;
      end
    end else if (way_ring[sel] < req_ring) begin
      cause_n = data_side ? CAUSE_D_PRIV : CAUSE_I_PRIV;
    end else if (!granted) begin
      if (!data_side)                  cause_n = CAUSE_I_PROHIB;
      else if (req_kind == ACC_STORE)  cause_n = CAUSE_ST_PROHIB;
      else                             cause_n = CAUSE_LD_PROHIB;
    end else begin
      paddr_n = {way_ppn[sel], req_vaddr[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_cause <= '0;
      rsp_paddr <= '0;
      rsp_probe <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_cause <= cause_n;
        rsp_paddr <= paddr_n;
        rsp_probe <= probe_n;
      end
    end
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int WAY_ENTRIES = 4,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ASID_W      = 8,
  parameter int NUM_RINGS   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_probe,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_ring,
  input  logic [31:0] req_vaddr,
  input  logic        wr_en,
  input  logic [1:0]  wr_way,
  input  logic [1:0]  wr_idx,
  input  logic [17:0] wr_tag,
  input  logic [19:0] wr_ppn,
  input  logic [3:0]  wr_attr,
  input  logic [1:0]  wr_ring,
  input  logic        inv_en,
  input  logic [1:0]  inv_way,
  input  logic [1:0]  inv_idx,
  input  logic        rasid_we,
  input  logic [31:0] rasid_wdata,
  output logic [31:0] rasid_q,
  output logic        rsp_valid,
  output logic [3:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_probe
);

  localparam int IDX_W  = $clog2(WAY_ENTRIES);
  localparam int WAY_W  = $clog2(NUM_WAYS);
  localparam int RING_W = $clog2(NUM_RINGS);
  localparam int TAG_W  = VA_W - PAGE_BITS - IDX_W;
  localparam int PPN_W  = PA_W - PAGE_BITS;

  logic [IDX_W-1:0]                    lk_idx;
  logic [TAG_W-1:0]                    lk_tag;
  logic [ASID_W-1:0]                   wr_asid;
  logic [NUM_WAYS-1:0]                 way_match;
  logic [NUM_WAYS-1:0]                 way_found;
  logic [NUM_WAYS-1:0]                 way_hit;
  logic [NUM_WAYS-1:0][ASID_W-1:0]     way_asid;
  logic [NUM_WAYS-1:0][RING_W-1:0]     way_ring;
  logic [NUM_WAYS-1:0][PPN_W-1:0]      way_ppn;
  logic [NUM_WAYS-1:0][ATTR_W-1:0]     way_attr;

  assign lk_idx = req_vaddr[PAGE_BITS +: IDX_W];
  assign lk_tag = req_vaddr[VA_W-1 -: TAG_W];

  asid_tlb_ringmap #(
    .NUM_RINGS(NUM_RINGS), .ASID_W(ASID_W), .NUM_PORTS(NUM_WAYS)
  ) i_ringmap (
    .clk(clk), .rst(rst), .we(rasid_we), .wdata(rasid_wdata),
    .rasid_q(rasid_q), .wr_sel(wr_ring), .wr_asid(wr_asid),
    .asids(way_asid), .found(way_found), .rings(way_ring)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    asid_tlb_way #(
      .ENTRIES(WAY_ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W),
      .ASID_W(ASID_W), .ATTR_W(ATTR_W)
    ) i_way (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && wr_way == WAY_W'(w)), .wr_idx(wr_idx),
      .wr_tag(wr_tag), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr),
      .inv_en(inv_en && inv_way == WAY_W'(w)), .inv_idx(inv_idx),
      .lk_idx(lk_idx), .lk_tag(lk_tag),
      .lk_match(way_match[w]), .lk_asid(way_asid[w]),
      .lk_ppn(way_ppn[w]), .lk_attr(way_attr[w])
    );
    assign way_hit[w] = way_match[w] && way_found[w];
  end

  asid_tlb_resolve #(
    .NUM_WAYS(NUM_WAYS), .RING_W(RING_W), .VA_W(VA_W),
    .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
  ) i_resolve (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_probe(req_probe),
    .req_kind(req_kind), .req_ring(req_ring), .req_vaddr(req_vaddr),
    .way_hit(way_hit), .way_ring(way_ring), .way_ppn(way_ppn),
    .way_attr(way_attr), .rsp_valid(rsp_valid), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .rsp_probe(rsp_probe)
  );

endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_probe,
  input logic [1:0]  req_kind,
  input logic        rasid_we,
  input logic [31:0] rasid_wdata,
  input logic [31:0] rasid_q,
  input logic        rsp_valid,
  input logic [3:0]  rsp_cause,
  input logic [31:0] rsp_paddr,
  input logic [31:0] rsp_probe
);

  p_rsp_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_ring0_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    rasid_q[7:0] == 8'h01);

  p_rasid_store_r8: assert property (@(posedge clk) disable iff (rst)
    rasid_we |=> rasid_q[31:8] == $past(rasid_wdata[31:8]));

  p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_cause != 4'd0) |-> rsp_paddr == 32'd0);

  p_fetch_side_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_probe && req_kind == 2'd2) |=> rsp_cause <= 4'd4);

  p_probe_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_probe != 32'd0) |-> (rsp_probe[4] != rsp_probe[3]));

  p_probe_noaddr_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_probe) |=> rsp_paddr == 32'd0);

endmodule

bind asid_tlb asid_tlb_checker i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_probe(req_probe),
  .req_kind(req_kind), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
  .rasid_q(rasid_q), .rsp_valid(rsp_valid), .rsp_cause(rsp_cause),
  .rsp_paddr(rsp_paddr), .rsp_probe(rsp_probe)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_probe = 0;
  logic [1:0]  req_kind = 0, req_ring = 0;
  logic [31:0] req_vaddr = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_way = 0, wr_idx = 0, wr_ring = 0;
  logic [17:0] wr_tag = 0;
  logic [19:0] wr_ppn = 0;
  logic [3:0]  wr_attr = 0;
  logic        inv_en = 0;
  logic [1:0]  inv_way = 0, inv_idx = 0;
  logic        rasid_we = 0;
  logic [31:0] rasid_wdata = 0;
  logic [31:0] rasid_q, rsp_paddr, rsp_probe;
  logic        rsp_valid;
  logic [3:0]  rsp_cause;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  asid_tlb i_asid_tlb (.*);

  // {probe, kind, ring, cause, vaddr, expected paddr or probe word}
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0,2'd0,2'd0,4'd0,32'h10000ABC,32'h80000ABC},
    {1'b0,2'd2,2'd1,4'd0,32'h10000ABC,32'h80000ABC},
    {1'b0,2'd1,2'd2,4'd7,32'h10000ABC,32'h0},
    {1'b0,2'd2,2'd3,4'd3,32'h10000ABC,32'h0},
    {1'b0,2'd0,2'd3,4'd0,32'h20001010,32'h12345010},
    {1'b0,2'd1,2'd0,4'd9,32'h20001010,32'h0},
    {1'b0,2'd2,2'd0,4'd4,32'h20001010,32'h0},
    {1'b0,2'd1,2'd0,4'd0,32'h30002FFF,32'h0ABCDFFF},
    {1'b0,2'd2,2'd0,4'd4,32'h30002FFF,32'h0},
    {1'b0,2'd0,2'd0,4'd8,32'h40003004,32'h0},
    {1'b0,2'd0,2'd3,4'd7,32'h40003004,32'h0},
    {1'b0,2'd2,2'd3,4'd0,32'h50000008,32'h00777008},
    {1'b0,2'd1,2'd1,4'd9,32'h50000008,32'h0},
    {1'b0,2'd0,2'd0,4'd5,32'h60000000,32'h0},
    {1'b0,2'd2,2'd0,4'd1,32'h60000000,32'h0},
    {1'b0,2'd0,2'd0,4'd5,32'h10001ABC,32'h0},
    {1'b1,2'd0,2'd2,4'd0,32'h20001010,32'h20001011},
    {1'b1,2'd2,2'd0,4'd0,32'h10000000,32'h10000008},
    {1'b1,2'd0,2'd2,4'd0,32'h10000000,32'h0},
    {1'b1,2'd3,2'd0,4'd0,32'h60000000,32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic lookup(input logic probe, input logic [1:0] kind,
                        input logic [1:0] ring, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1; req_probe = probe; req_kind = kind; req_ring = ring; req_vaddr = va;
    @(negedge clk);
    req_valid = 0; req_probe = 0;
  endtask

  task automatic put(input logic [1:0] way, input logic [31:0] va, input logic [19:0] ppn,
                     input logic [3:0] attr, input logic [1:0] ring);
    @(negedge clk);
    wr_en = 1; wr_way = way; wr_idx = va[13:12]; wr_tag = va[31:14];
    wr_ppn = ppn; wr_attr = attr; wr_ring = ring;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic kill(input logic [1:0] way, input logic [1:0] idx);
    @(negedge clk);
    inv_en = 1; inv_way = way; inv_idx = idx;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic set_map(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1; rasid_wdata = v;
    @(negedge clk);
    rasid_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 rasid_q", rasid_q, 32'h04030201);
    chk("R1 cause", {28'd0, rsp_cause}, 32'd0);
    chk("R1 paddr", rsp_paddr, 32'd0);
    lookup(0, 2'd0, 2'd0, 32'h0);
    chk("R1 empty load miss", {28'd0, rsp_cause}, 32'd5);
    lookup(0, 2'd2, 2'd0, 32'h0);
    chk("R1 empty fetch miss", {28'd0, rsp_cause}, 32'd1);

    // R4 entries take the identifier of byte wr_ring
    put(2'd0, 32'h10000000, 20'h80000, 4'd3,  2'd1);
    put(2'd1, 32'h20001000, 20'h12345, 4'd0,  2'd3);
    put(2'd2, 32'h30002000, 20'h0ABCD, 4'd13, 2'd0);
    put(2'd3, 32'h40003000, 20'h55555, 4'd12, 2'd2);
    put(2'd3, 32'h50000000, 20'h00777, 4'd1,  2'd3);

    // R2 R5 R6 R7 R9 table walk
    for (int v = 0; v < NV; v++) begin
      lookup(VEC[v][72], VEC[v][71:70], VEC[v][69:68], VEC[v][63:32]);
      chk($sformatf("R2/R5/R6/R7/R9 vec %0d cause", v), {28'd0, rsp_cause}, {28'd0, VEC[v][67:64]});
      if (VEC[v][72]) begin
        chk($sformatf("R9 vec %0d probe", v), rsp_probe, VEC[v][31:0]);
        chk($sformatf("R9 vec %0d paddr", v), rsp_paddr, 32'd0);
      end else begin
        chk($sformatf("R2/R7 vec %0d paddr", v), rsp_paddr, VEC[v][31:0]);
      end
    end

    // R10 strobe lasts one cycle, data holds
    lookup(0, 2'd0, 2'd0, 32'h30002123);
    chk("R10 valid", {31'd0, rsp_valid}, 32'd1);
    chk("R10 paddr", rsp_paddr, 32'h0ABCD123);
    @(negedge clk);
    chk("R10 valid drop", {31'd0, rsp_valid}, 32'd0);
    chk("R10 hold", rsp_paddr, 32'h0ABCD123);

    // R4 ring position follows the map
    set_map(32'h02030401);
    chk("R8 map", rasid_q, 32'h02030401);
    lookup(0, 2'd1, 2'd3, 32'h10000ABC);
    chk("R4 remap ring3 ok", rsp_paddr, 32'h80000ABC);
    lookup(0, 2'd0, 2'd3, 32'h20001010);
    chk("R4 remap ring1 priv", {28'd0, rsp_cause}, 32'd7);
    // R8 low byte forced
    set_map(32'h0A0B0CFF);
    chk("R8 low byte forced", rasid_q, 32'h0A0B0C01);
    lookup(0, 2'd0, 2'd0, 32'h10000ABC);
    chk("R4 absent asid misses", {28'd0, rsp_cause}, 32'd5);
    lookup(0, 2'd0, 2'd0, 32'h30002004);
    chk("R4 ring0 asid stays", rsp_paddr, 32'h0ABCD004);
    set_map(32'h04030201);

    // R5 multi-hit
    put(2'd1, 32'h10000000, 20'h99999, 4'd3, 2'd0);
    lookup(0, 2'd0, 2'd0, 32'h10000ABC);
    chk("R5 data multi", {28'd0, rsp_cause}, 32'd6);
    chk("R5 multi paddr", rsp_paddr, 32'd0);
    lookup(0, 2'd2, 2'd0, 32'h10000ABC);
    chk("R5 fetch multi", {28'd0, rsp_cause}, 32'd2);
    lookup(1, 2'd0, 2'd0, 32'h10000ABC);
    chk("R9 probe multi cause", {28'd0, rsp_cause}, 32'd6);
    chk("R9 probe multi word", rsp_probe, 32'd0);
    kill(2'd1, 2'd0);
    lookup(0, 2'd0, 2'd0, 32'h10000ABC);
    chk("R3 single hit after invalidate", rsp_paddr, 32'h80000ABC);

    // R10 lookup in write cycle sees old state
    @(negedge clk);
    wr_en = 1; wr_way = 2'd0; wr_idx = 2'd1; wr_tag = 18'h1C000; wr_ppn = 20'h31415;
    wr_attr = 4'd3; wr_ring = 2'd0;
    req_valid = 1; req_probe = 0; req_kind = 2'd0; req_ring = 2'd0; req_vaddr = 32'h70001234;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R10 same-cycle write unseen", {28'd0, rsp_cause}, 32'd5);
    lookup(0, 2'd0, 2'd0, 32'h70001234);
    chk("R10 write seen next", rsp_paddr, 32'h31415234);

    // R3 invalidate beats write, invalidate clears
    @(negedge clk);
    wr_en = 1; wr_way = 2'd2; wr_idx = 2'd2; wr_tag = 18'h0C000; wr_ppn = 20'h0ABCD;
    wr_attr = 4'd13; wr_ring = 2'd0;
    inv_en = 1; inv_way = 2'd2; inv_idx = 2'd2;
    @(negedge clk);
    wr_en = 0; inv_en = 0;
    lookup(0, 2'd0, 2'd0, 32'h30002FFF);
    chk("R3 invalidate wins", {28'd0, rsp_cause}, 32'd5);
    kill(2'd0, 2'd0);
    lookup(0, 2'd0, 2'd0, 32'h10000ABC);
    chk("R3 invalidated misses", {28'd0, rsp_cause}, 32'd5);

    done = 1;
    summary();
    $finish;
  end

endmodule